// File: doc/BRIEF.md
# Multi-Bank Program/Erase Arbiter

This block tracks the operating state of a flash array that is split into independent banks. Each cycle it takes at most one request carrying an operation code and a block number. It converts the block number to a bank number and applies the dual-operation rules. Only one program or erase may be in flight at a time. Reads to any bank not taken by that operation are answered with array data, with no more latency than when the array is idle.

The array has sixteen banks. Fifteen banks hold eight large blocks each. The remaining parameter bank holds eight small parameter blocks and seven large blocks, so the array has 135 blocks in all. An input selects whether the parameter bank sits at the low or the high end of the block numbering.

An erase can be suspended, and a program can then be run in a different block before the erase is resumed. A program can be suspended so that other blocks can be read, and then resumed. The array's program and erase time is modelled by a fixed busy latency of `BUSY_CYCLES` running cycles. That count stops while the operation is suspended. Sticky status bits report completion and four kinds of error. A dedicated request clears them.

Top module: `flash_arb`

## Requirements
- R1: Block-to-bank mapping. With `param_top`=0, blocks 0..14 are bank 0 and block b≥15 is bank (b-15)/8+1. With `param_top`=1, block b<120 is bank b/8 and blocks 120..134 are bank 15. A read, program or erase naming a block ≥135 does nothing except set `status[4]`, and such a read answers with status.
- R2: Request codes on `req_op` are 1 read, 2 program, 3 erase, 4 suspend, 5 resume and 6 clear status; 0 and 7 do nothing. One cycle after any read request, `rd_ack` is 1 for one cycle. `rd_bank` then gives the bank of the read block, and `rd_data` is 1 when array data is returned and 0 when status is returned.
- R3: A program or erase accepted while idle raises `busy` in the next cycle and keeps it high for exactly `BUSY_CYCLES` cycles. `busy` then falls and `status[0]` (done) is set.
- R4: A program or erase request made while any operation is running or suspended is refused. The operation in progress is not affected, and `status[1]` is set. The one exception is a program during erase-suspend, covered by R7.
- R5: While `busy` is high, `act_bank` gives the bank of the running operation. A read to any other bank returns data. A read to that bank returns status and sets `status[2]`.
- R6: A suspend during an erase clears `busy` and sets `ers_susp` in the next cycle. The remaining latency is kept, and after a resume the erase runs only for the cycles it had left.
- R7: During erase-suspend, a program to any block other than the one being erased starts. `busy` and `ers_susp` are both high while it runs, and it ends after `BUSY_CYCLES` cycles with `ers_susp` still high and `status[0]` set. A program to the block being erased is refused and sets `status[3]`. While the nested program runs, a read to the block being erased returns status.
- R8: A suspend during a program clears `busy` and sets `prg_susp`. Reads to other blocks, including blocks in the same bank, return data. A read to the suspended block returns status and sets `status[2]`. A resume completes the remaining cycles.
- R9: Suspend and resume requests that have nothing to act on, and codes 0 and 7, change no state and no status bit.
- R10: A clear-status request zeroes `status`. A completion in the same cycle still sets `status[0]`.
- R11: After reset the block is idle, with `busy`, `ers_susp`, `prg_susp`, `rd_ack` and `status` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| param_top | input | 1 | 1 places the parameter bank at the high end of the block numbers |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code |
| req_blk | input | 8 | Target block number |
| busy | output | 1 | A program or erase is running |
| ers_susp | output | 1 | An erase is suspended |
| prg_susp | output | 1 | A program is suspended |
| act_bank | output | 4 | Bank of the running operation |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 1 | Read response carries array data (0: status) |
| rd_bank | output | 4 | Bank of the answered read |
| status | output | 5 | Sticky bits: 0 done, 1 refused, 2 access, 3 suspended-target, 4 address |

## Verification
The assertions watch the properties that can be judged without knowing the bank map. On every cycle they check the following:
- Every read gets a response, and a data response always comes with an acknowledge.
- A refused request, an out-of-range address or a clear is reflected in `status` one cycle later.
- A suspended program never coexists with another activity, and it holds until a resume.
- Every completion that is not a suspension sets the done bit.

The bench's scenarios are needed for the rest:
- The exact bank of each of the 135 blocks in both layouts.
- The busy window length, and the cycles left after a suspend and resume.
- The refusal of a nested program aimed at the suspended erase block.
- The choice between data and status for reads that land next to, or inside, the busy bank.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_READ   = 3'd1,
    OP_PROG   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_CLRST  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PROG  = 3'd1,
    S_ERASE = 3'd2,
    S_ESUS  = 3'd3,
    S_NPROG = 3'd4,
    S_PSUS  = 3'd5
  } arb_state_e;

  localparam int SB_DONE = 0;
  localparam int SB_SEQ  = 1;
  localparam int SB_ACC  = 2;
  localparam int SB_TGT  = 3;
  localparam int SB_ADDR = 4;
  localparam int SB_W    = 5;

endpackage

// File: rtl/flash_arb_map.sv
module flash_arb_map #(
  parameter int NUM_BANKS     = 16,
  parameter int MAIN_PER_BANK = 8,
  parameter int PARAM_BLKS    = 8,
  parameter int PARAM_MAIN    = 7,
  parameter int BLK_W         = 8,
  parameter int BANK_W        = 4
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic              param_top,
  output logic [BANK_W-1:0] bank,
  output logic              in_range
);
  localparam int PB_BLKS   = PARAM_BLKS + PARAM_MAIN;
  localparam int UNI_BLKS  = (NUM_BANKS - 1) * MAIN_PER_BANK;
  localparam int TOTAL     = UNI_BLKS + PB_BLKS;
  localparam int SH        = $clog2(MAIN_PER_BANK);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BLK_W-1:0] off;

  always_comb begin
    in_range = (int'(blk) < TOTAL);
    off      = '0;
    if (param_top) begin
      if (int'(blk) < UNI_BLKS) bank = BANK_W'(blk >> SH);
      else                      bank = LAST_BANK;
    end else begin
      if (int'(blk) < PB_BLKS) begin
        bank = '0;
      end else begin
        off  = blk - BLK_W'(PB_BLKS);
        bank = BANK_W'(off >> SH) + BANK_W'(1);
      end
    end
  end
endmodule

// File: rtl/flash_arb_lat.sv
module flash_arb_lat #(
  parameter int LAT = 16,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | run;
    if (load)                   cnt_d = CW'(LAT);
    else if (cnt_q == CW'(1))   cnt_d = '0;
    else                        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/flash_arb_sts.sv
module flash_arb_sts #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | (|set);
    q_d  = (clr ? '0 : q) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/flash_arb.sv
module flash_arb #(
  parameter int NUM_BANKS     = 16,
  parameter int MAIN_PER_BANK = 8,
  parameter int PARAM_BLKS    = 8,
  parameter int PARAM_MAIN    = 7,
  parameter int BUSY_CYCLES   = 16,
  localparam int NUM_BLOCKS   = (NUM_BANKS - 1) * MAIN_PER_BANK + PARAM_BLKS + PARAM_MAIN,
  localparam int BLK_W        = $clog2(NUM_BLOCKS),
  localparam int BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              param_top,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              busy,
  output logic              ers_susp,
  output logic              prg_susp,
  output logic [BANK_W-1:0] act_bank,
  output logic              rd_ack,
  output logic              rd_data,
  output logic [BANK_W-1:0] rd_bank,
  output logic [4:0]        status
);
  import flash_arb_pkg::*;

  op_e               op;
  arb_state_e        state_q, state_d;
  logic [BANK_W-1:0] req_bank;
  logic              req_ok;
  logic              is_rd, is_pg, is_er, is_su, is_re, is_cl;
  logic              rd_ok, pg_ok, er_ok, pe_ok, hit;
  logic              prg_start, ers_start, pri_ld, nst_ld;
  logic              seq_err, tgt_err, done_set;
  logic              prg_last, ers_last, prg_run, ers_run;
  logic [BLK_W-1:0]  pri_blk_q;
  logic [BANK_W-1:0] pri_bank_q, nst_bank_q;
  logic [SB_W-1:0]   sts_set;
  logic              rd_ack_q, rd_data_q;
  logic [BANK_W-1:0] rd_bank_q;

  flash_arb_map #(
    .NUM_BANKS(NUM_BANKS), .MAIN_PER_BANK(MAIN_PER_BANK),
    .PARAM_BLKS(PARAM_BLKS), .PARAM_MAIN(PARAM_MAIN),
    .BLK_W(BLK_W), .BANK_W(BANK_W)
  ) u_map (
    .blk(req_blk), .param_top(param_top), .bank(req_bank), .in_range(req_ok)
  );

  // request decode
  always_comb begin
    op    = op_e'(req_op);
    is_rd = req_valid && (op == OP_READ);
    is_pg = req_valid && (op == OP_PROG);
    is_er = req_valid && (op == OP_ERASE);
    is_su = req_valid && (op == OP_SUSP);
    is_re = req_valid && (op == OP_RESUME);
    is_cl = req_valid && (op == OP_CLRST);
    rd_ok = is_rd && req_ok;
    pg_ok = is_pg && req_ok;
    er_ok = is_er && req_ok;
    pe_ok = pg_ok | er_ok;
  end

  // does a read collide with the running or suspended operation
  always_comb begin
    case (state_q)
      S_PROG, S_ERASE: hit = (req_bank == pri_bank_q);
      S_ESUS, S_PSUS:  hit = (req_blk == pri_blk_q);
      S_NPROG:         hit = (req_bank == nst_bank_q) || (req_blk == pri_blk_q);
      default:         hit = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    prg_start = 1'b0;
    ers_start = 1'b0;
    pri_ld    = 1'b0;
    nst_ld    = 1'b0;
    seq_err   = 1'b0;
    tgt_err   = 1'b0;
    done_set  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (pg_ok) begin
          state_d = S_PROG; prg_start = 1'b1; pri_ld = 1'b1;
        end else if (er_ok) begin
          state_d = S_ERASE; ers_start = 1'b1; pri_ld = 1'b1;
        end
      end
      S_PROG: begin
        seq_err = pe_ok;
        if (prg_last) begin
          state_d = S_IDLE; done_set = 1'b1;
        end else if (is_su) begin
          state_d = S_PSUS;
        end
      end
      S_ERASE: begin
        seq_err = pe_ok;
        if (ers_last) begin
          state_d = S_IDLE; done_set = 1'b1;
        end else if (is_su) begin
          state_d = S_ESUS;
        end
      end
      S_ESUS: begin
        seq_err = er_ok;
        if (is_re) begin
          state_d = S_ERASE;
        end else if (pg_ok) begin
          if (req_blk == pri_blk_q) begin
            tgt_err = 1'b1;
          end else begin
            state_d = S_NPROG; prg_start = 1'b1; nst_ld = 1'b1;
          end
        end
      end
      S_NPROG: begin
        seq_err = pe_ok;
        if (prg_last) begin
          state_d = S_ESUS; done_set = 1'b1;
        end
      end
      S_PSUS: begin
        seq_err = pe_ok;
        if (is_re) state_d = S_PROG;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_blk_q  <= '0;
      pri_bank_q <= '0;
    end else if (pri_ld) begin
      pri_blk_q  <= req_blk;
      pri_bank_q <= req_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nst_bank_q <= '0;
    else if (nst_ld) nst_bank_q <= req_bank;
  end

  // busy latency models
  assign prg_run = (state_q == S_PROG) || (state_q == S_NPROG);
  assign ers_run = (state_q == S_ERASE);

  flash_arb_lat #(.LAT(BUSY_CYCLES)) u_prg_lat (
    .clk(clk), .rst_n(rst_n), .load(prg_start), .run(prg_run), .last(prg_last)
  );

  flash_arb_lat #(.LAT(BUSY_CYCLES)) u_ers_lat (
    .clk(clk), .rst_n(rst_n), .load(ers_start), .run(ers_run), .last(ers_last)
  );

  // sticky status
  always_comb begin
    sts_set          = '0;
    sts_set[SB_DONE] = done_set;
    sts_set[SB_SEQ]  = seq_err;
    sts_set[SB_ACC]  = rd_ok && hit;
    sts_set[SB_TGT]  = tgt_err;
    sts_set[SB_ADDR] = (is_rd | is_pg | is_er) && !req_ok;
  end

  flash_arb_sts #(.W(SB_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(is_cl), .q(status)
  );

  // read response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack_q  <= 1'b0;
      rd_data_q <= 1'b0;
    end else begin
      rd_ack_q  <= is_rd;
      rd_data_q <= rd_ok && !hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_bank_q <= '0;
    else if (is_rd) rd_bank_q <= req_bank;
  end

  assign rd_ack   = rd_ack_q;
  assign rd_data  = rd_data_q;
  assign rd_bank  = rd_bank_q;
  assign busy     = prg_run || ers_run;
  assign ers_susp = (state_q == S_ESUS) || (state_q == S_NPROG);
  assign prg_susp = (state_q == S_PSUS);
  assign act_bank = (state_q == S_NPROG) ? nst_bank_q : pri_bank_q;
endmodule

// File: rtl/flash_arb_chk.sv
module flash_arb_chk #(
  parameter int NUM_BLOCKS = 135,
  parameter int BLK_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [BLK_W-1:0] req_blk,
  input logic             busy,
  input logic             ers_susp,
  input logic             prg_susp,
  input logic             rd_ack,
  input logic             rd_data,
  input logic [4:0]       status
);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd1 |=> rd_ack);

  // R2
  rd_data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |-> rd_ack);

  // R4
  seq_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && (req_op == 3'd2 || req_op == 3'd3) && int'(req_blk) < NUM_BLOCKS
    |=> status[1]);

  // R1
  addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd3) && int'(req_blk) >= NUM_BLOCKS
    |=> status[4]);

  // R8
  psus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_susp |-> !busy && !ers_susp);

  // R8
  psus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_susp && !(req_valid && req_op == 3'd5) |=> prg_susp);

  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !ers_susp && !prg_susp |-> status[0]);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd6 && !busy |=> status == 5'd0);
endmodule

bind flash_arb flash_arb_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
  .busy(busy), .ers_susp(ers_susp), .prg_susp(prg_susp), .rd_ack(rd_ack),
  .rd_data(rd_data), .status(status)
);

// File: tb/flash_arb_test.sv
`timescale 1ns/1ps
module flash_arb_test;
  localparam int LAT = 6;

  logic       clk, rst_n, param_top, req_valid;
  logic [2:0] req_op;
  logic [7:0] req_blk;
  logic       busy, ers_susp, prg_susp, rd_ack, rd_data;
  logic [3:0] act_bank, rd_bank;
  logic [4:0] status;
  int total = 0;
  int bad = 0;

  flash_arb #(.BUSY_CYCLES(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .param_top(param_top), .req_valid(req_valid),
    .req_op(req_op), .req_blk(req_blk), .busy(busy), .ers_susp(ers_susp),
    .prg_susp(prg_susp), .act_bank(act_bank), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_bank(rd_bank), .status(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int blk);
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_blk   = 8'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 3'd0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  function automatic int exp_bank(input int b, input int top);
    if (top != 0) return (b < 120) ? b / 8 : 15;
    return (b < 15) ? 0 : (b - 15) / 8 + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; param_top = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_blk = 8'd0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 busy", int'(busy), 0);
    check("R11 susp", int'({ers_susp, prg_susp}), 0);
    check("R11 rd_ack", int'(rd_ack), 0);
    check("R11 status", int'(status), 0);

    // R1 R2 full map sweep in both layouts
    for (int pt = 0; pt < 2; pt++) begin
      param_top = pt[0];
      for (int b = 0; b < 135; b++) begin
        issue(1, b);
        check("R2 ack", int'(rd_ack), 1);
        check("R2 data", int'(rd_data), 1);
        check("R1 bank", int'(rd_bank), exp_bank(b, pt));
      end
    end
    param_top = 1'b0;
    check("R1 no err in range", int'(status), 0);
    issue(1, 135);
    check("R1 oor read ack", int'(rd_ack), 1);
    check("R1 oor read status", int'(rd_data), 0);
    check("R1 addr bit", int'(status[4]), 1);
    issue(2, 255);
    check("R1 oor prog ignored", int'(busy), 0);
    issue(6, 0);
    check("R10 clear", int'(status), 0);

    // R3 busy window length
    issue(2, 3);
    check("R3 busy start", int'(busy), 1);
    for (int i = 1; i < LAT; i++) begin
      tick(1);
      check("R3 busy held", int'(busy), 1);
    end
    tick(1);
    check("R3 busy end", int'(busy), 0);
    check("R3 done", int'(status), 1);

    // R4 R5 erase in bank 5 with reads around it
    issue(6, 0);
    issue(3, 50);
    check("R5 act_bank", int'(act_bank), 5);
    issue(1, 60);
    check("R5 other bank data", int'(rd_data), 1);
    check("R5 other bank id", int'(rd_bank), 6);
    issue(1, 51);
    check("R5 busy bank status", int'(rd_data), 0);
    check("R5 acc bit", int'(status[2]), 1);
    issue(2, 80);
    check("R4 seq bit", int'(status[1]), 1);
    check("R4 still busy", int'(busy), 1);
    check("R4 bank kept", int'(act_bank), 5);
    wait_idle();
    check("R4 final status", int'(status), 7);

    // R6 erase suspend and resume keep remaining latency
    issue(6, 0);
    issue(3, 10);
    tick(1);
    issue(4, 0);
    check("R6 busy off", int'(busy), 0);
    check("R6 ers_susp", int'(ers_susp), 1);
    tick(5);
    check("R6 held", int'({busy, ers_susp}), 1);
    check("R6 no done", int'(status[0]), 0);
    issue(5, 0);
    check("R6 resumed", int'(busy), 1);
    for (int i = 1; i < LAT - 2; i++) begin
      tick(1);
      check("R6 remaining", int'(busy), 1);
    end
    tick(1);
    check("R6 finish", int'(busy), 0);
    check("R6 done", int'(status[0]), 1);

    // R7 nested program during erase suspend
    issue(6, 0);
    issue(3, 100);
    issue(4, 0);
    check("R7 suspended", int'(ers_susp), 1);
    issue(2, 100);
    check("R7 tgt bit", int'(status[3]), 1);
    check("R7 refused", int'(busy), 0);
    issue(6, 0);
    issue(2, 101);
    check("R7 nested busy", int'({busy, ers_susp}), 3);
    check("R7 nested bank", int'(act_bank), 11);
    issue(1, 100);
    check("R7 erase blk read", int'(rd_data), 0);
    for (int i = 2; i < LAT; i++) begin
      tick(1);
      check("R7 nested held", int'(busy), 1);
    end
    tick(1);
    check("R7 nested end", int'({busy, ers_susp}), 1);
    check("R7 done", int'(status[0]), 1);
    issue(5, 0);
    check("R7 erase resumed", int'({busy, ers_susp}), 2);
    wait_idle();
    check("R7 erase finished", int'({busy, ers_susp}), 0);

    // R8 program suspend
    issue(6, 0);
    issue(2, 130);
    issue(4, 0);
    check("R8 prg_susp", int'({busy, prg_susp}), 1);
    issue(1, 131);
    check("R8 same bank data", int'(rd_data), 1);
    check("R8 same bank id", int'(rd_bank), 15);
    issue(1, 130);
    check("R8 own block status", int'(rd_data), 0);
    check("R8 acc bit", int'(status[2]), 1);
    issue(5, 0);
    check("R8 resumed", int'({busy, prg_susp}), 2);
    wait_idle();
    check("R8 done", int'(status), 5);

    // R9 no-op requests while idle
    issue(6, 0);
    issue(4, 0);
    issue(5, 0);
    issue(0, 7);
    issue(7, 7);
    check("R9 state", int'({busy, ers_susp, prg_susp}), 0);
    check("R9 status", int'(status), 0);

    // R10 clear coinciding with completion
    issue(2, 2);
    tick(LAT - 1);
    issue(6, 0);
    check("R10 idle", int'(busy), 0);
    check("R10 done survives", int'(status), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule